// File: doc/BRIEF.md
# Scan-Path Signature Compactor

This block is a 16-bit signature register that sits beside the serial scan path of a test-access bridge. It compacts the data streaming out of the active scan chain into a signature without sitting in that chain. Later it can be switched into the chain as an ordinary shift register, so the signature can be read out or a seed can be loaded.

The TAP controller and the instruction decoder sit outside the block. They tell the block when Update-IR and Shift-DR occur, and they supply a 2-bit decoded command. The block has three modes:

- **Hold**: the register keeps its value.
- **Compact**: the register folds each bit of the chain data into the signature. The bit flows on to TDO unchanged.
- **Select**: the register shifts between TDI and TDO with its feedback disabled.

The register updates on the rising edge of TCK. TDO is retimed on the falling edge.

Top module: `scan_sig_compactor`

## Requirements
- R1: While `trst_n` is low, the signature is all zeros, the mode is hold and `tdo` is 0.
- R2: On a rising TCK edge with `ir_update` high, `ir_code` sets the mode. 2'b01 selects compact, 2'b10 selects hold and 2'b11 selects select. 2'b00 (any other instruction) leaves compact or hold unchanged and moves select to hold.
- R3: In compact mode with `shift_dr` high, each rising edge computes `fb = sig[0] ^ chain_in` and sets `sig <= (sig >> 1) ^ (fb ? 16'h8408 : 0)`. This is the reflected Galois form of x^16+x^12+x^5+1.
- R4: Compaction leaves the serial data unaltered: in compact mode `tdo` carries `chain_in`.
- R5: In compact mode the signature changes only on edges where `shift_dr` is high.
- R6: In select mode with `shift_dr` high, each rising edge sets `sig <= {tdi, sig[15:1]}`, with no feedback.
- R7: In select mode, `tdo` takes `sig[0]` on each falling TCK edge. A 16-bit seed shifted in LSB first reads back unchanged, LSB first.
- R8: In hold mode the signature keeps its value whatever `shift_dr`, `tdi` and `chain_in` do.
- R9: While `ir_update` is low, `ir_code` has no effect on the mode.
- R10: Outside select mode, `tdo` takes `chain_in` on each falling TCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir_update | input | 1 | High during the Update-IR state |
| ir_code | input | 2 | Decoded command (see R2) |
| shift_dr | input | 1 | High during the Shift-DR state |
| tdi | input | 1 | Serial input used in select mode |
| chain_in | input | 1 | Active scan-chain data heading to TDO |
| tdo | output | 1 | Serial output, changes on the falling edge |

## Verification
The bench compacts a long random stream, with non-shift cycles and stray commands mixed in, and then reads the signature back through select mode. A wrong tap position, a wrong bit order, or sampling outside Shift-DR would give a signature that differs from the software model.

A seed round trip catches a select mode that leaves feedback enabled or shifts the wrong way. Both would corrupt the read-back value.

The bench also sends an "other" command while in select and while in compact. A design that kept select active would steal TDO from the chain, and one that dropped compaction would miss part of the stream.

Finally, the bench toggles the data inputs while in hold and while `ir_update` is low. This exposes a design whose signature drifts in hold or that decodes commands outside Update-IR.

// File: rtl/scan_sig_pkg.sv
package scan_sig_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD    = 2'b00,
      MODE_COMPACT = 2'b01,
      MODE_SELECT  = 2'b10
   } sig_mode_e;

   localparam logic [1:0] CMD_OTHER   = 2'b00;
   localparam logic [1:0] CMD_COMPACT = 2'b01;
   localparam logic [1:0] CMD_HOLD    = 2'b10;
   localparam logic [1:0] CMD_SELECT  = 2'b11;

   // Mode after Update-IR for a given command.
   function automatic sig_mode_e decode_mode(input sig_mode_e cur, input logic [1:0] cmd);
      sig_mode_e nxt;
      case (cmd)
         CMD_COMPACT: nxt = MODE_COMPACT;
         CMD_HOLD:    nxt = MODE_HOLD;
         CMD_SELECT:  nxt = MODE_SELECT;
         default:     nxt = (cur == MODE_SELECT) ? MODE_HOLD : cur;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/sig_mode_reg.sv
module sig_mode_reg
   import scan_sig_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       ir_update,
   input  logic [1:0] ir_code,
   output sig_mode_e  mode_o
);

   sig_mode_e mode_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         mode_q <= MODE_HOLD;
      end else if (ir_update) begin
         mode_q <= decode_mode(mode_q, ir_code);
      end
   end

   assign mode_o = mode_q;

   // R9: command ignored outside Update-IR
   p_mode_only_on_update_r9: assert property (@(posedge tck) disable iff (!trst_n)
      !ir_update |=> $stable(mode_q));

   // R2: an unrelated instruction ends select mode
   p_select_exit_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_update && ir_code == CMD_OTHER && mode_q == MODE_SELECT) |=> (mode_q == MODE_HOLD));

endmodule

// File: rtl/sig_lfsr_core.sv
module sig_lfsr_core
   import scan_sig_pkg::*;
#(
   parameter int          WIDTH = 16,
   parameter logic [WIDTH-1:0] POLY = 16'h8408
)(
   input  logic             tck,
   input  logic             trst_n,
   input  sig_mode_e        mode,
   input  logic             shift_dr,
   input  logic             tdi,
   input  logic             chain_in,
   output logic [WIDTH-1:0] sig_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("sig_lfsr_core: WIDTH must be at least 2");
   end
   if (POLY[WIDTH-1] != 1'b1) begin : g_bad_poly
      $error("sig_lfsr_core: POLY top bit must be set");
   end

   logic [WIDTH-1:0] sig_q;
   logic [WIDTH-1:0] comp_nxt;
   logic [WIDTH-1:0] sel_nxt;
   logic [WIDTH-1:0] sig_d;
   logic             fb;

   assign fb = sig_q[0] ^ chain_in;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == WIDTH - 1) begin : g_top
         assign comp_nxt[i] = POLY[i] & fb;
         assign sel_nxt[i]  = tdi;
      end else begin : g_mid
         assign comp_nxt[i] = sig_q[i+1] ^ (POLY[i] & fb);
         assign sel_nxt[i]  = sig_q[i+1];
      end
   end

   always_comb begin
      sig_d = sig_q;
      if (shift_dr) begin
         case (mode)
            MODE_COMPACT: sig_d = comp_nxt;
            MODE_SELECT:  sig_d = sel_nxt;
            default:      sig_d = sig_q;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) sig_q <= '0;
      else         sig_q <= sig_d;
   end

   assign sig_o = sig_q;

   // R8: hold mode keeps the signature
   p_hold_keeps_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == MODE_HOLD) |=> $stable(sig_q));

   // R5: compaction only during Shift-DR
   p_compact_idle_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == MODE_COMPACT && !shift_dr) |=> $stable(sig_q));

   // R6: select mode is a plain right shift fed by tdi
   p_select_shift_r6: assert property (@(posedge tck) disable iff (!trst_n)
      (mode == MODE_SELECT && shift_dr) |=>
         (sig_q[WIDTH-1] == $past(tdi) && sig_q[WIDTH-2:0] == $past(sig_q[WIDTH-1:1])));

endmodule

// File: rtl/sig_tdo_stage.sv
module sig_tdo_stage (
   input  logic tck,
   input  logic trst_n,
   input  logic use_sig,
   input  logic sig_lsb,
   input  logic chain_in,
   output logic tdo
);

   logic tdo_q;

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) tdo_q <= 1'b0;
      else         tdo_q <= use_sig ? sig_lsb : chain_in;
   end

   assign tdo = tdo_q;

   // R1: output low while reset is held
   always_comb begin
      if (!trst_n) begin
         a_tdo_reset_r1: assert (tdo_q == 1'b0 || $isunknown(tdo_q));
      end
   end

endmodule

// File: rtl/scan_sig_compactor.sv
module scan_sig_compactor
   import scan_sig_pkg::*;
#(
   parameter int          WIDTH = 16,
   parameter logic [WIDTH-1:0] POLY = 16'h8408
)(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       ir_update,
   input  logic [1:0] ir_code,
   input  logic       shift_dr,
   input  logic       tdi,
   input  logic       chain_in,
   output logic       tdo
);

   sig_mode_e        mode;
   logic [WIDTH-1:0] sig;

   sig_mode_reg u_mode (
      .tck       (tck),
      .trst_n    (trst_n),
      .ir_update (ir_update),
      .ir_code   (ir_code),
      .mode_o    (mode)
   );

   sig_lfsr_core #(.WIDTH(WIDTH), .POLY(POLY)) u_core (
      .tck      (tck),
      .trst_n   (trst_n),
      .mode     (mode),
      .shift_dr (shift_dr),
      .tdi      (tdi),
      .chain_in (chain_in),
      .sig_o    (sig)
   );

   sig_tdo_stage u_out (
      .tck      (tck),
      .trst_n   (trst_n),
      .use_sig  (mode == MODE_SELECT),
      .sig_lsb  (sig[0]),
      .chain_in (chain_in),
      .tdo      (tdo)
   );

endmodule

// File: tb/scan_sig_compactor_test.sv
`timescale 1ns/1ps
module scan_sig_compactor_test;

   logic       tck = 1'b0;
   logic       trst_n = 1'b0;
   logic       ir_update = 1'b0;
   logic [1:0] ir_code = 2'b00;
   logic       shift_dr = 1'b0;
   logic       tdi = 1'b0;
   logic       chain_in = 1'b0;
   logic       tdo;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic  exp_q[$];
   string tag_q[$];

   logic [15:0] m_sig = 16'h0;
   int          m_mode = 0; // 0 hold, 1 compact, 2 select

   always #10 tck = ~tck;

   scan_sig_compactor uut (
      .tck(tck), .trst_n(trst_n), .ir_update(ir_update), .ir_code(ir_code),
      .shift_dr(shift_dr), .tdi(tdi), .chain_in(chain_in), .tdo(tdo)
   );

   task automatic check_bit(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s tdo actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   // Driver: applies one TCK cycle of stimulus and pushes the expected tdo.
   task automatic step(input logic upd, input logic [1:0] code, input logic sh,
                       input logic di, input logic ci, input bit chk, input string tag);
      logic fb;
      @(negedge tck); #1;
      ir_update = upd; ir_code = code; shift_dr = sh; tdi = di; chain_in = ci;
      @(posedge tck); #1;
      if (sh) begin
         if (m_mode == 1) begin
            fb = m_sig[0] ^ ci;
            m_sig = (m_sig >> 1) ^ (fb ? 16'h8408 : 16'h0000);
         end else if (m_mode == 2) begin
            m_sig = {di, m_sig[15:1]};
         end
      end
      if (upd) begin
         case (code)
            2'b01: m_mode = 1;
            2'b10: m_mode = 0;
            2'b11: m_mode = 2;
            default: if (m_mode == 2) m_mode = 0;
         endcase
      end
      if (chk) begin
         exp_q.push_back((m_mode == 2) ? m_sig[0] : ci);
         tag_q.push_back(tag);
      end
   endtask

   // Monitor: compares tdo after each falling edge.
   initial begin
      forever begin
         @(negedge tck); #3;
         if (exp_q.size() > 0) begin
            check_bit(tdo, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic read_sig(input string tag);
      step(1, 2'b11, 0, 0, $urandom_range(1), 1, "R2");
      for (int i = 0; i < 16; i++) step(0, 2'b00, 1, $urandom_range(1), 0, 1, tag);
      step(1, 2'b00, 0, 0, 1, 1, "R2");
   endtask

   initial begin
      void'($urandom(32'h5eed1234));
      repeat (3) @(posedge tck);
      #5 check_bit(tdo, 1'b0, "R1");
      @(negedge tck); #2 trst_n = 1'b1;

      // R10: hold mode passes chain data through
      for (int i = 0; i < 8; i++) step(0, 2'b00, 1, 1, $urandom_range(1), 1, "R10");

      // R1/R7: after reset signature reads zero while a seed goes in
      step(1, 2'b11, 0, 0, 0, 1, "R1");
      for (int i = 0; i < 16; i++) step(0, 2'b00, 1, ((16'hA5C3 >> i) & 1), 0, 1, "R1");
      // R7/R6: seed reads back LSB first
      for (int i = 0; i < 16; i++) step(0, 2'b00, 1, ((16'h3C5A >> i) & 1), 0, 1, "R7");

      // R2: other instruction leaves select; R8: hold keeps contents
      step(1, 2'b00, 0, 0, 1, 1, "R2");
      for (int i = 0; i < 20; i++)
         step(0, 2'b00, $urandom_range(1), $urandom_range(1), $urandom_range(1), 1, "R8");
      read_sig("R8");

      // R9: commands without Update-IR have no effect (still hold: tdo follows chain)
      for (int i = 0; i < 6; i++) step(0, 2'b11, 1, 0, $urandom_range(1), 1, "R9");

      // Compaction of a random stream
      step(1, 2'b01, 0, 0, 0, 1, "R4");
      for (int i = 0; i < 300; i++) begin
         logic sh = ($urandom_range(3) != 0);
         logic upd = ($urandom_range(15) == 0);
         step(upd, upd ? 2'b00 : 2'(($urandom_range(3))), sh, $urandom_range(1),
              $urandom_range(1), 1, sh ? "R4" : "R5");
      end
      step(1, 2'b10, 1, 0, 1, 1, "R3");
      read_sig("R3");

      // Seeded compaction, then off and hold before readout
      step(1, 2'b11, 0, 0, 0, 1, "R6");
      for (int i = 0; i < 16; i++) step(0, 2'b00, 1, ((16'hBEEF >> i) & 1), 0, 1, "R6");
      step(1, 2'b01, 0, 0, 0, 1, "R2");
      for (int i = 0; i < 100; i++) step(0, 2'b00, 1, 0, $urandom_range(1), 1, "R3");
      step(1, 2'b10, 0, 0, 0, 1, "R2");
      for (int i = 0; i < 10; i++) step(0, 2'b00, 1, 1, $urandom_range(1), 1, "R8");
      read_sig("R3");

      repeat (3) @(negedge tck);
      #5;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule